// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block collects 8-bit frames arriving on a clocked synchronous serial link. The serial clock and data pins come from outside the system clock domain, so both pass through a two-flop synchronizer. A rising edge of the synchronized serial clock samples one data bit into a shift register. The first bit of a frame lands in bit 0 of the byte and the last bit lands in bit 7. When a frame is complete, the byte moves into a host-visible data register, but only if the host has released the previous byte.

The host uses a small register port with a write strobe, an address and combinational read data. The status register holds a receive-full flag and an overrun flag, and the host clears each flag by writing 1 to it. If a frame completes while the previous byte is still unclaimed, the block keeps the old byte, latches an overrun and stops receiving. Reception stays stopped until the host clears the overrun.

Two level-sensitive interrupt requests follow the flags. Both are gated by one interrupt enable. A receive enable holds the frame logic at bit 0 while it is off.

Top module: `clksync_rx`

## Requirements
- R1: Bits are assembled least significant first: the first sampled bit of a frame appears at bit 0 of the data register and the eighth at bit 7.
- R2: When a frame completes and the receive-full flag is 0, the byte is copied into the data register and the receive-full flag becomes 1.
- R3: When a frame completes while the receive-full flag is 1, the overrun flag becomes 1 and the data register keeps its previous byte.
- R4: While the overrun flag is 1, arriving frames are discarded and the receive-full flag is not set. After the overrun is cleared, the next frame is assembled starting from bit 0.
- R5: Writing to the status address (1) clears receive-full when write bit 0 is 1 and clears overrun when write bit 1 is 1. A written 0 leaves that flag unchanged.
- R6: If a receive-full clear is written in the same system clock cycle as a frame completes, the set wins: the new byte is stored, receive-full stays 1, and no overrun is raised.
- R7: `irq_rx_full` is 1 exactly while receive-full and the interrupt enable are both 1.
- R8: `irq_rx_err` is 1 exactly while overrun and the interrupt enable are both 1.
- R9: While the receive enable is 0, serial clock edges are ignored and the bit position is held at 0. A partial frame is discarded when the receive enable turns off.
- R10: After reset the data register, both flags, both enables and both interrupt requests read 0.
- R11: Register map on `reg_addr`:
  - Address 0 reads the data register.
  - Address 1 reads status, with receive-full in bit 0 and overrun in bit 1.
  - Address 2 reads and writes control, with the receive enable in bit 0 and the interrupt enable in bit 1.
  - Address 3 reads 0.
  - Unused read bits are 0.
- R12: The data bit is sampled at the rising edge of the serial clock. A data change made two or more system clocks after that edge does not alter the bit. The serial clock must hold each level for at least 3 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the link, asynchronous |
| ser_data | input | 1 | Serial data from the link, asynchronous |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2 | Register write data (flag clears or enable bits) |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_rx_full | output | 1 | Receive-full interrupt request, level |
| irq_rx_err | output | 1 | Receive-error (overrun) interrupt request, level |

## Verification
The hardest case to reach from the ports is the R6 collision, where a receive-full clear lands in the very system clock cycle in which a frame completes. The synchronizer and edge detector place that cycle a fixed number of clocks after the last serial clock rise. The stimulus counts falling system clock edges from the moment it raises the final serial clock and asserts the clear write exactly in that cycle. Overrun recovery (R4) and the mid-frame disable (R9) are reached by sending partial frames and by leaving bytes unclaimed across randomized frame sequences.

// File: rtl/clksync_rx_pkg.sv
package clksync_rx_pkg;
  localparam int ADDR_W = 2;
  localparam int WD_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 2'd0,
    A_STAT = 2'd1,
    A_CTRL = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;

  localparam int ST_FULL = 0;
  localparam int ST_OVR  = 1;
  localparam int CT_EN   = 0;
  localparam int CT_IE   = 1;
endpackage

// File: rtl/csrx_sync_edge.sv
module csrx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_async,
  input  logic sd_async,
  output logic sck_rise,
  output logic sd_sync
);
  logic [STAGES:0]   sck_q;
  logic [STAGES-1:0] sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      sd_q  <= '0;
    end else begin
      sck_q <= {sck_q[STAGES-1:0], sck_async};
      sd_q  <= {sd_q[STAGES-2:0], sd_async};
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign sd_sync  = sd_q[STAGES-1];
endmodule

// File: rtl/csrx_shifter.sv
module csrx_shifter #(
  parameter int W = 8,
  localparam int CNT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             sample,
  input  logic             bit_in,
  output logic             frame_done,
  output logic [W-1:0]     frame_data,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      bit_cnt <= '0;
    end else if (hold) begin
      sh_q    <= '0;
      bit_cnt <= '0;
    end else if (sample) begin
      sh_q    <= {bit_in, sh_q[W-2:1]};
      bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + CNT_W'(1);
    end
  end

  assign frame_done = sample & ~hold & (bit_cnt == LAST);
  assign frame_data = {bit_in, sh_q};
endmodule

// File: rtl/csrx_flags.sv
module csrx_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_done,
  input  logic [W-1:0] frame_data,
  input  logic         clr_full,
  input  logic         clr_ovr,
  output logic [W-1:0] data_q,
  output logic         full_q,
  output logic         ovr_q
);
  logic full_eff, take, overrun;

  // a clear in this cycle frees the register before the transfer decision
  assign full_eff = full_q & ~clr_full;
  assign take     = frame_done & ~full_eff;
  assign overrun  = frame_done & full_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= take | full_eff;
      ovr_q  <= overrun | (ovr_q & ~clr_ovr);
      if (take) data_q <= frame_data;
    end
  end
endmodule

// File: rtl/clksync_rx.sv
module clksync_rx
  import clksync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WD_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_rx_full,
  output logic              irq_rx_err
);
  logic              sck_rise, sd_sync;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data, data_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic              full_q, ovr_q;
  logic              rx_en_q, ie_q;
  logic              clr_full, clr_ovr, hold;
  reg_addr_e         addr;

  assign addr     = reg_addr_e'(reg_addr);
  assign clr_full = reg_we & (addr == A_STAT) & reg_wdata[ST_FULL];
  assign clr_ovr  = reg_we & (addr == A_STAT) & reg_wdata[ST_OVR];
  assign hold     = ~rx_en_q | ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      ie_q    <= 1'b0;
    end else if (reg_we && addr == A_CTRL) begin
      rx_en_q <= reg_wdata[CT_EN];
      ie_q    <= reg_wdata[CT_IE];
    end
  end

  csrx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_async(ser_clk), .sd_async(ser_data),
    .sck_rise(sck_rise), .sd_sync(sd_sync)
  );

  csrx_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sample(sck_rise), .bit_in(sd_sync),
    .frame_done(frame_done), .frame_data(frame_data), .bit_cnt(bit_cnt)
  );

  csrx_flags #(.W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .clr_full(clr_full), .clr_ovr(clr_ovr),
    .data_q(data_q), .full_q(full_q), .ovr_q(ovr_q)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (addr)
      A_DATA: reg_rdata = data_q;
      A_STAT: begin
        reg_rdata[ST_FULL] = full_q;
        reg_rdata[ST_OVR]  = ovr_q;
      end
      A_CTRL: begin
        reg_rdata[CT_EN] = rx_en_q;
        reg_rdata[CT_IE] = ie_q;
      end
      A_RSVD: reg_rdata = '0;
    endcase
  end

  assign irq_rx_full = full_q & ie_q;
  assign irq_rx_err  = ovr_q & ie_q;
endmodule

// File: rtl/clksync_rx_chk.sv
module clksync_rx_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_done,
  input logic              clr_full,
  input logic              clr_ovr,
  input logic              full_q,
  input logic              ovr_q,
  input logic              rx_en_q,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] data_q,
  input logic              irq_rx_err
);
  // R2
  take_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !full_q |=> full_q);
  // R3
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && full_q && !clr_full |=> ovr_q && $stable(data_q));
  // R4
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !clr_ovr |=> ovr_q);
  // R4
  ovr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> bit_cnt == '0 && !frame_done);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && clr_full |=> full_q && !ovr_q);
  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_q |=> bit_cnt == '0);
  // R3
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(frame_done) && $past(full_q));
  // R8
  err_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_err |-> ovr_q);
endmodule

bind clksync_rx clksync_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .clr_full(clr_full),
  .clr_ovr(clr_ovr), .full_q(full_q), .ovr_q(ovr_q), .rx_en_q(rx_en_q),
  .bit_cnt(bit_cnt), .data_q(data_q), .irq_rx_err(irq_rx_err)
);

// File: tb/sim_clksync_rx.sv
module sim_clksync_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_data = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [1:0] reg_wdata = 2'd0;
  logic [7:0] reg_rdata;
  logic       irq_rx_full, irq_rx_err;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] m_data;
  bit m_full, m_ovr, m_en, m_ie;

  always #10 clk = ~clk;

  clksync_rx u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_ctrl(bit en, bit ie);
    wr(2'd2, {ie, en});
    m_en = en; m_ie = ie;
  endtask

  function automatic void model_frame(logic [7:0] b, bit clr_same);
    if (!m_en || m_ovr) return;
    if (clr_same) m_full = 0;
    if (m_full) m_ovr = 1;
    else begin m_data = b; m_full = 1; end
  endfunction

  // nbits bits of b, LSB first; optional clear collision on the last bit,
  // optional late data flip during the high phase
  task automatic send_bits(logic [7:0] b, int nbits, bit clr_last, bit late_flip);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      ser_clk = 1'b0; ser_data = b[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      if (clr_last && i == nbits - 1) begin
        @(negedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 2'b01;
        @(negedge clk);
        reg_we = 1'b0;
        repeat (2) @(negedge clk);
      end else if (late_flip) begin
        @(negedge clk);
        @(negedge clk);
        ser_data = ~ser_data;
        @(negedge clk);
      end else begin
        repeat (3) @(negedge clk);
      end
    end
    @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_state(string req);
    logic [7:0] d;
    rd(2'd0, d); chk({req, " data"}, d, m_data);
    rd(2'd1, d); chk({req, " status"}, d, {6'd0, m_ovr, m_full});
    chk({req, " R7 irq_rx_full"}, {7'd0, irq_rx_full}, {7'd0, m_full & m_ie});
    chk({req, " R8 irq_rx_err"}, {7'd0, irq_rx_err}, {7'd0, m_ovr & m_ie});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] b;
    void'($urandom(32'd20240611));
    m_data = 0; m_full = 0; m_ovr = 0; m_en = 0; m_ie = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check_state("R10");
    rd(2'd2, d); chk("R10 ctrl", d, 8'h00);
    // R11 reserved address and control readback
    rd(2'd3, d); chk("R11 addr3", d, 8'h00);
    set_ctrl(1, 1);
    rd(2'd2, d); chk("R11 ctrl readback", d, 8'h03);

    // R9 frame while disabled is ignored
    set_ctrl(0, 1);
    send_bits(8'hA5, 8, 0, 0);
    check_state("R9 disabled");
    set_ctrl(1, 1);

    // R1 R2 single-bit position
    send_bits(8'h01, 8, 0, 0); model_frame(8'h01, 0);
    check_state("R1 bit0");
    wr(2'd1, 2'b01); m_full = 0;
    check_state("R5 clear full");
    send_bits(8'h80, 8, 0, 0); model_frame(8'h80, 0);
    check_state("R1 bit7");

    // R3 overrun keeps old byte
    send_bits(8'h3C, 8, 0, 0); model_frame(8'h3C, 0);
    check_state("R3 overrun");
    // R5 write 0 leaves flags
    wr(2'd1, 2'b00);
    check_state("R5 write zero");
    // R4 frames ignored during overrun
    send_bits(8'h55, 8, 0, 0); model_frame(8'h55, 0);
    check_state("R4 blocked");
    wr(2'd1, 2'b11); m_ovr = 0; m_full = 0;
    check_state("R4 cleared");
    send_bits(8'hC3, 8, 0, 0); model_frame(8'hC3, 0);
    check_state("R4 resume");

    // R6 clear collides with frame completion while full
    send_bits(8'h96, 8, 1, 0); model_frame(8'h96, 1);
    check_state("R6 set wins");
    wr(2'd1, 2'b01); m_full = 0;

    // R9 partial frame discarded on disable
    send_bits(8'hFF, 3, 0, 0);
    set_ctrl(0, 1);
    set_ctrl(1, 1);
    send_bits(8'h4E, 8, 0, 0); model_frame(8'h4E, 0);
    check_state("R9 partial discarded");
    wr(2'd1, 2'b01); m_full = 0;

    // R12 late data change does not alter sampled bit
    send_bits(8'h6B, 8, 0, 1); model_frame(8'h6B, 0);
    check_state("R12 late flip");

    // random sequence
    for (int it = 0; it < 40; it++) begin
      int act;
      act = $urandom % 5;
      b = 8'($urandom);
      case (act)
        0: begin rd(2'd0, d); wr(2'd1, 2'b01); m_full = 0; end
        1: begin wr(2'd1, 2'b10); m_ovr = 0; end
        2: begin wr(2'd1, 2'b11); m_ovr = 0; m_full = 0; end
        3: set_ctrl(1, ($urandom % 2) == 1);
        default: ;
      endcase
      send_bits(b, 8, 0, 0); model_frame(b, 0);
      check_state("R2 R3 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule